// File: doc/BRIEF.md
# Humidity Sensor Poller

This block takes one reading from a combined humidity and temperature sensor over a two-wire I2C bus, where it is the only master. A one-cycle pulse on `start_i` starts a measurement. The block first sends a write transaction that carries only the sensor's address, which tells the sensor to start converting. It then waits a fixed conversion time, 60 ms by default. After the wait it opens a read transaction and collects four bytes. The sensor returns the previous result if it is read too early, so the trigger and the wait are never skipped.

The bus lines are open-drain. The block never drives a line high. It only pulls SCL or SDA low through an output-enable pin and lets the external pull-up raise the line when released. The SCL rate and the length of the wait both come from the system clock frequency parameter. When the read finishes, the 32-bit raw result appears with a single-cycle valid strobe. If the sensor fails to acknowledge its address, the block ends the transfer cleanly and raises an error flag instead.

Top module: `hygro_poller`

## Requirements
- R1: After reset both line enables are low (both lines released), and `busy_o`, `valid_o` and `err_o` are low.
- R2: A start pulse while idle produces a START, the address byte `{DEV_ADDR, 0}` (0x50 for the default address 0x28) sent most significant bit first, and then a STOP. No data byte is sent.
- R3: The read START never begins until at least WAIT_CYC = CLK_HZ*WAIT_US/1e6 clock cycles have passed since the trigger STOP.
- R4: The read sends the address byte `{DEV_ADDR, 1}` (0x51), receives exactly four bytes, acknowledges bytes one to three with SDA low, leaves byte four unacknowledged with SDA released, and then sends a STOP.
- R5: The four bytes are packed so that the first byte received sits in bits 31:24 and the last in bits 7:0. `valid_o` is high for exactly one cycle, and `data_o` holds its value until the next successful read.
- R6: `busy_o` goes high in the cycle after an accepted start and stays high until the block is idle again. Start pulses that arrive while busy have no effect: each accepted start gives exactly one trigger write and at most one read.
- R7: If the address is not acknowledged during the trigger write, the block sends a STOP, performs no read, and does not assert `valid_o`. It then returns to idle with `err_o` high. `err_o` clears when the next start is accepted.
- R8: If the address is not acknowledged during the read, the block sends a STOP, asserts `err_o` and does not assert `valid_o`.
- R9: SDA changes while SCL is released only as part of a START or STOP condition. While idle, both lines are released.
- R10: Every SCL high pulse of a data or acknowledge bit lasts 2*QTR cycles, where QTR = CLK_HZ/(4*SCL_HZ).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one measurement |
| sda_i | input | 1 | Level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Measurement in progress |
| valid_o | output | 1 | One-cycle strobe: new result on data_o |
| data_o | output | 32 | Raw four-byte reading, first byte in the top bits |
| err_o | output | 1 | Last measurement aborted on an address NACK |

## Verification
The hardest cases to reach are the NACK paths, especially the one where the sensor acknowledges the trigger write but refuses the later read. In that case the block must issue a STOP in the middle of the sequence and still keep its trigger count right. The bench's sensor model has separate acknowledge enables for the write address and the read address, and random runs mix these failures with normal reads. The model also timestamps every STOP and START on the bus to measure the conversion gap. It feeds back a fresh random reading after each trigger, which shows any stale or reordered byte packing.

// File: rtl/hyg_pkg.sv
package hyg_pkg;

  typedef enum logic [1:0] {
    PHY_START = 2'd0,
    PHY_BIT   = 2'd1,
    PHY_STOP  = 2'd2
  } phy_op_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_TRG_START,
    SQ_TRG_ADDR,
    SQ_TRG_STOP,
    SQ_WAIT,
    SQ_RD_START,
    SQ_RD_ADDR,
    SQ_RD_DATA,
    SQ_RD_STOP,
    SQ_ABORT
  } seq_state_e;

  localparam int unsigned BYTE_BITS    = 8;
  localparam int unsigned RESULT_BYTES = 4;

  // Line pull-down pattern {scl_oe, sda_oe} for one quarter of an operation.
  function automatic logic [1:0] drive_lines(phy_op_e op, logic [1:0] ph, logic b);
    logic [1:0] r;
    case (op)
      PHY_START: begin
        case (ph)
          2'd0:    r = 2'b00;
          2'd3:    r = 2'b11;
          default: r = 2'b01;
        endcase
      end
      PHY_STOP: begin
        case (ph)
          2'd0:    r = 2'b11;
          2'd1:    r = 2'b01;
          default: r = 2'b00;
        endcase
      end
      default: r = {(ph == 2'd0) || (ph == 2'd3), ~b};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hyg_tick.sv
module hyg_tick #(
  parameter int unsigned PERIOD = 500
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || (cnt_q == '0)) cnt_d = RELOAD;
    else                        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RELOAD;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == '0) && !clr_i;

endmodule

// File: rtl/hyg_delay.sv
module hyg_delay #(
  parameter int unsigned CYC = 12_000_000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (load_i) begin
      cnt_d = CW'(CYC);
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q <= CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  // R3: the sequencer never restarts a wait that is still running.
  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> !run_q);

endmodule

// File: rtl/hyg_bitphy.sv
module hyg_bitphy
  import hyg_pkg::*;
#(
  parameter int unsigned QTR = 500
) (
  input  logic    clk,
  input  logic    rst_ni,
  input  logic    req_i,
  input  phy_op_e op_i,
  input  logic    bit_i,
  output logic    done_o,
  output logic    bit_o,
  input  logic    sda_i,
  output logic    scl_oe_o,
  output logic    sda_oe_o
);
  logic       active_q, active_d;
  phy_op_e    op_q, op_d;
  logic       bit_q, bit_d;
  logic [1:0] ph_q, ph_d;
  logic       scl_q, scl_d, sda_q, sda_d;
  logic       rx_q, rx_d;
  logic       done_q, done_d;
  logic       sda_m_q, sda_s_q;
  logic       accept, tick;

  assign accept = req_i && !active_q;

  hyg_tick #(.PERIOD(QTR)) u_tick (
    .clk    (clk),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .tick_o (tick)
  );

  always_comb begin
    active_d       = active_q;
    op_d           = op_q;
    bit_d          = bit_q;
    ph_d           = ph_q;
    {scl_d, sda_d} = {scl_q, sda_q};
    rx_d           = rx_q;
    done_d         = 1'b0;
    if (accept) begin
      active_d       = 1'b1;
      op_d           = op_i;
      bit_d          = bit_i;
      ph_d           = 2'd0;
      {scl_d, sda_d} = drive_lines(op_i, 2'd0, bit_i);
    end else if (active_q && tick) begin
      if (ph_q == 2'd3) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else begin
        ph_d           = ph_q + 2'd1;
        {scl_d, sda_d} = drive_lines(op_q, ph_q + 2'd1, bit_q);
        if (ph_q == 2'd2) rx_d = sda_s_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      op_q     <= PHY_STOP;
      bit_q    <= 1'b1;
      ph_q     <= 2'd0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
      rx_q     <= 1'b1;
      done_q   <= 1'b0;
      sda_m_q  <= 1'b1;
      sda_s_q  <= 1'b1;
    end else begin
      active_q <= active_d;
      op_q     <= op_d;
      bit_q    <= bit_d;
      ph_q     <= ph_d;
      scl_q    <= scl_d;
      sda_q    <= sda_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
      sda_m_q  <= sda_i;
      sda_s_q  <= sda_m_q;
    end
  end

  assign done_o   = done_q;
  assign bit_o    = rx_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;

  // R9: SDA may move under a released SCL only inside START or STOP.
  a_r9_sda_edge_in_condition: assert property (@(posedge clk) disable iff (!rst_ni)
    (!scl_q && !$past(scl_q) && !$stable(sda_q)) |-> (op_q == PHY_START || op_q == PHY_STOP));

  // R9: the sequencer only hands over a new operation when the engine is free.
  a_r9_req_only_when_free: assert property (@(posedge clk) disable iff (!rst_ni)
    req_i |-> !active_q);

endmodule

// File: rtl/hygro_poller.sv
module hygro_poller
  import hyg_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 200_000_000,
  parameter int unsigned SCL_HZ   = 100_000,
  parameter int unsigned WAIT_US  = 60_000,
  parameter logic [6:0]  DEV_ADDR = 7'h28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o,
  output logic        busy_o,
  output logic        valid_o,
  output logic [31:0] data_o,
  output logic        err_o
);
  localparam int unsigned QTR      = CLK_HZ / (4 * SCL_HZ);
  localparam longint     WAIT_L    = (longint'(CLK_HZ) * longint'(WAIT_US)) / 64'd1000000;
  localparam int unsigned WAIT_CYC = int'(WAIT_L);
  localparam int unsigned RES_W    = RESULT_BYTES * BYTE_BITS;
  localparam int unsigned BYC_W    = $clog2(RESULT_BYTES);
  localparam logic [BYC_W-1:0] LAST_BYTE = BYC_W'(RESULT_BYTES - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_ni  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_ni  <= rst_m_q;
    end
  end

  seq_state_e       st_q, st_d;
  logic             pend_q, pend_d;
  logic [3:0]       bitc_q, bitc_d;
  logic [BYC_W-1:0] bytec_q, bytec_d;
  logic [RES_W-1:0] shf_q, shf_d;
  logic [RES_W-1:0] data_q, data_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;

  logic    phy_req, phy_txb, phy_done, phy_rxb;
  phy_op_e phy_op;
  logic    dly_load, dly_done;
  logic    cmd_state;
  logic [7:0] addr_byte;
  logic [2:0] bsel;

  hyg_bitphy #(.QTR(QTR)) u_phy (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .req_i    (phy_req),
    .op_i     (phy_op),
    .bit_i    (phy_txb),
    .done_o   (phy_done),
    .bit_o    (phy_rxb),
    .sda_i    (sda_i),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );

  hyg_delay #(.CYC(WAIT_CYC)) u_delay (
    .clk    (clk),
    .rst_ni (rst_ni),
    .load_i (dly_load),
    .done_o (dly_done)
  );

  assign addr_byte = {DEV_ADDR, (st_q == SQ_RD_ADDR)};
  assign bsel      = 3'd7 - bitc_q[2:0];
  assign cmd_state = (st_q != SQ_IDLE) && (st_q != SQ_WAIT);
  assign phy_req   = cmd_state && !pend_q;

  always_comb begin
    phy_op  = PHY_BIT;
    phy_txb = 1'b1;
    case (st_q)
      SQ_TRG_START, SQ_RD_START: phy_op = PHY_START;
      SQ_TRG_STOP, SQ_RD_STOP, SQ_ABORT: phy_op = PHY_STOP;
      SQ_TRG_ADDR, SQ_RD_ADDR: phy_txb = bitc_q[3] ? 1'b1 : addr_byte[bsel];
      SQ_RD_DATA: phy_txb = bitc_q[3] ? (bytec_q == LAST_BYTE) : 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    st_d     = st_q;
    bitc_d   = bitc_q;
    bytec_d  = bytec_q;
    shf_d    = shf_q;
    data_d   = data_q;
    err_d    = err_q;
    valid_d  = 1'b0;
    dly_load = 1'b0;
    pend_d   = phy_req ? 1'b1 : (phy_done ? 1'b0 : pend_q);
    case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          st_d    = SQ_TRG_START;
          err_d   = 1'b0;
          bitc_d  = '0;
          bytec_d = '0;
        end
      end
      SQ_TRG_START, SQ_RD_START: begin
        if (phy_done) begin
          st_d   = (st_q == SQ_TRG_START) ? SQ_TRG_ADDR : SQ_RD_ADDR;
          bitc_d = '0;
        end
      end
      SQ_TRG_ADDR, SQ_RD_ADDR: begin
        if (phy_done) begin
          if (bitc_q[3]) begin
            bitc_d  = '0;
            bytec_d = '0;
            if (phy_rxb)                  st_d = SQ_ABORT;
            else if (st_q == SQ_TRG_ADDR) st_d = SQ_TRG_STOP;
            else                          st_d = SQ_RD_DATA;
          end else begin
            bitc_d = bitc_q + 4'd1;
          end
        end
      end
      SQ_TRG_STOP: begin
        if (phy_done) begin
          st_d     = SQ_WAIT;
          dly_load = 1'b1;
        end
      end
      SQ_WAIT: begin
        if (dly_done) st_d = SQ_RD_START;
      end
      SQ_RD_DATA: begin
        if (phy_done) begin
          if (!bitc_q[3]) begin
            shf_d  = {shf_q[RES_W-2:0], phy_rxb};
            bitc_d = bitc_q + 4'd1;
          end else if (bytec_q == LAST_BYTE) begin
            st_d = SQ_RD_STOP;
          end else begin
            bytec_d = bytec_q + 1'b1;
            bitc_d  = '0;
          end
        end
      end
      SQ_RD_STOP: begin
        if (phy_done) begin
          st_d    = SQ_IDLE;
          data_d  = shf_q;
          valid_d = 1'b1;
        end
      end
      SQ_ABORT: begin
        if (phy_done) begin
          st_d  = SQ_IDLE;
          err_d = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      pend_q  <= 1'b0;
      bitc_q  <= '0;
      bytec_q <= '0;
      shf_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      pend_q  <= pend_d;
      bitc_q  <= bitc_d;
      bytec_q <= bytec_d;
      shf_q   <= shf_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign err_o   = err_q;

  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r7_valid_excludes_err: assert property (@(posedge clk) disable iff (!rst_ni)
    valid_q |-> !err_q);

  a_r3_read_after_wait: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == SQ_RD_START && $past(st_q) == SQ_WAIT) |-> $past(dly_done));

  a_r4_stop_after_last_byte: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == SQ_RD_STOP) |-> (bytec_q == LAST_BYTE));

endmodule

// File: tb/hygro_poller_bench.sv
`timescale 1ns/1ps
module hygro_poller_bench;
  localparam int unsigned CLK_HZ   = 200_000_000;
  localparam int unsigned SCL_HZ   = 25_000_000;
  localparam int unsigned WAIT_US  = 1;
  localparam int          QTR      = CLK_HZ / (4 * SCL_HZ);
  localparam int          WAIT_CYC = (CLK_HZ / 1000000) * WAIT_US;
  localparam logic [6:0]  ADDR     = 7'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic scl_oe, sda_oe, busy, valid, err;
  logic [31:0] data;
  logic s_drv = 1'b0;
  logic scl_line, sda_line;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | s_drv);

  always #2.5 clk = ~clk;

  hygro_poller #(
    .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .WAIT_US(WAIT_US), .DEV_ADDR(ADDR)
  ) u_hygro_poller (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .valid_o(valid),
    .data_o(data), .err_o(err)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] exp_addr(input logic rw);
    return {ADDR, rw};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // sensor model
  bit ack_wr = 1, ack_rd = 1;
  logic p_scl = 1, p_sda = 1, rw = 0, rise_ok = 0;
  logic [7:0] sh = 0, last_addr = 0;
  logic [31:0] cur_meas = 0;
  int sl_ph = 0, bitc = 0, byte_i = 0;
  int trig_cnt = 0, rd_cnt = 0, wr_bits = 0, nack_at = -1;
  int stop_cyc = 0, start_cyc = 0, gap_last = 0, rise_cyc = 0, pulse_bad = 0;

  always @(negedge clk) begin
    logic scl, sda;
    scl = scl_line;
    sda = sda_line;
    if (p_scl && scl && p_sda && !sda) begin
      sl_ph = 1; bitc = 0; sh = 0; s_drv = 0; start_cyc = cyc; rise_ok = 0;
    end else if (p_scl && scl && !p_sda && sda) begin
      sl_ph = 0; s_drv = 0; stop_cyc = cyc; rise_ok = 0;
    end else if (!p_scl && scl) begin
      rise_cyc = cyc; rise_ok = 1;
      if (sl_ph == 1) begin
        if (bitc < 8) sh = {sh[6:0], sda};
        bitc++;
      end else if (sl_ph == 3) begin
        if (bitc == 8 && sda) nack_at = byte_i;
        bitc++;
      end
    end else if (p_scl && !scl) begin
      if (rise_ok && (cyc - rise_cyc != 2 * QTR)) pulse_bad++;
      rise_ok = 0;
      if (sl_ph == 1) begin
        if (bitc == 8) begin
          rw = sh[0]; last_addr = sh;
          if (sh[7:1] == ADDR && (sh[0] ? ack_rd : ack_wr)) begin
            s_drv = 1;
            if (!sh[0]) begin trig_cnt++; cur_meas = $urandom; end
            else begin rd_cnt++; gap_last = start_cyc - stop_cyc; end
          end else begin
            s_drv = 0; sl_ph = 0;
          end
        end else if (bitc == 9) begin
          s_drv = 0; bitc = 0;
          if (rw) begin sl_ph = 3; byte_i = 0; s_drv = ~cur_meas[31]; end
          else sl_ph = 2;
        end
      end else if (sl_ph == 2) begin
        wr_bits++;
      end else if (sl_ph == 3) begin
        if (bitc < 8) s_drv = ~cur_meas[31 - (byte_i * 8 + bitc)];
        else if (bitc == 8) s_drv = 0;
        else if (nack_at == byte_i) begin sl_ph = 0; s_drv = 0; end
        else begin byte_i++; bitc = 0; s_drv = ~cur_meas[31 - byte_i * 8]; end
      end
    end
    p_scl = scl;
    p_sda = sda;
  end

  task automatic run_meas(input bit wr_ok, input bit rd_ok, input int extra, input int hold);
    int t0, r0, vcount;
    bit ok;
    logic [31:0] got;
    t0 = trig_cnt; r0 = rd_cnt; vcount = 0; got = 0;
    ok = wr_ok && rd_ok;
    ack_wr = wr_ok; ack_rd = rd_ok; nack_at = -1; wr_bits = 0; last_addr = 0;
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    chk(busy == 1, "R6 busy after start", busy, 1);
    chk(err == 0, "R7 err cleared by start", err, 0);
    for (int k = 0; k < extra; k++) begin
      repeat (1 + ($urandom % 20)) @(negedge clk);
      start_i = 1;
      @(negedge clk) start_i = 0;
    end
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (valid) begin vcount++; got = data; end
      if (!busy) break;
    end
    chk(busy == 0, "R6 busy drops at end", busy, 0);
    chk(vcount == (ok ? 1 : 0), "R5 valid strobe count", vcount, ok ? 1 : 0);
    chk(err == !ok, wr_ok ? "R8 err on read NACK" : "R7 err on trigger NACK", err, !ok);
    chk(trig_cnt - t0 == (wr_ok ? 1 : 0), "R6 one trigger per start", trig_cnt - t0, wr_ok ? 1 : 0);
    chk(rd_cnt - r0 == (ok ? 1 : 0), "R8 reads per start", rd_cnt - r0, ok ? 1 : 0);
    chk(scl_oe == 0 && sda_oe == 0, "R9 lines released when idle", {scl_oe, sda_oe}, 0);
    chk(pulse_bad == 0, "R10 SCL high width", pulse_bad, 0);
    if (ok) begin
      chk(got == cur_meas, "R5 packed result", got, cur_meas);
      chk(nack_at == 3, "R4 NACK on fourth byte only", nack_at, 3);
      chk(last_addr == exp_addr(1'b1), "R4 read address byte", last_addr, exp_addr(1'b1));
      chk(gap_last >= WAIT_CYC, "R3 conversion wait", gap_last, WAIT_CYC);
      chk(wr_bits == 0, "R2 no data byte in trigger", wr_bits, 0);
      repeat (hold) @(negedge clk);
      chk(data == got && valid == 0, "R5 result held", data, got);
    end else if (!wr_ok) begin
      chk(last_addr == exp_addr(1'b0), "R2 trigger address byte", last_addr, exp_addr(1'b0));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && valid == 0 && err == 0, "R1 flags low", {busy, valid, err}, 0);
    run_meas(1, 1, 0, 5);
    run_meas(1, 1, 3, 2);
    run_meas(0, 1, 1, 0);
    run_meas(1, 0, 2, 0);
    run_meas(1, 1, 0, 3);
    for (int i = 0; i < 16; i++) begin
      int pick;
      pick = $urandom % 8;
      repeat ($urandom % 50) @(negedge clk);
      run_meas(pick != 0, pick != 1, $urandom % 4, $urandom % 10);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule